// File: doc/BRIEF.md
# Supervisor Double-Trap Guard Control

This block keeps the supervisor double-trap flag for two supervisor status views: the host view and the guest (virtualized) view. It also keeps the double-trap enable bits of the machine-level and hypervisor-level environment-configuration registers. A chain of enables decides whether each flag can be seen and written. The machine enable gates the host flag and the hypervisor enable. The hypervisor enable, qualified by the machine enable, gates the guest flag. When software reads one of the four registers, the block returns data with only its own fields filled in. Every other bit reads as zero.

A trap that enters supervisor mode is signalled by a strobe, one per view. The strobe raises the flag when the view's enable chain allows it, and it always turns off the view's interrupt enable. The strobe is one cycle wide. Return events (machine return, supervisor return, debug return) arrive as pulses. Each pulse comes with the privilege and virtualization mode being returned to, and the supervisor return also carries the mode it executes in. The block clears the flags that each kind of return requires. An event always wins over a register write made in the same cycle, and that write is dropped.

Top module: `sdt_guard_ctrl`

## Requirements
- R1: After reset, all four registers read zero: both flags, both interrupt enables and both enable bits.
- R2: The host status view is selected by code 0. Bit 24 is the flag and bit 1 is the interrupt enable. The flag reads 0 and is not written while the machine enable is 0. The stored value is kept, and it is visible again once the enable returns to 1.
- R3: The guest status view is selected by code 1, with the same bit positions as R2. Its flag reads 0 and is not written unless both the machine enable and the stored hypervisor enable are 1.
- R4: The machine enable is bit 59 at code 2, and the hypervisor enable is bit 59 at code 3. The hypervisor enable reads 0 while the machine enable is 0. A write to it is ignored while the machine enable is 0.
- R5: On a status write, if the stored flag is 1 after the write, the interrupt enable becomes 0. Otherwise the interrupt enable takes the written bit 1.
- R6: A machine return or a debug return clears the host flag when the target privilege is user (0) or the target is virtualized. It also clears the guest flag when the target is virtualized user mode. Privilege codes are user 0, supervisor 1, machine 3.
- R7: A supervisor return that executes in supervisor mode clears the flag of the view it runs in: the guest flag when the current mode is virtualized, the host flag otherwise. When it runs non-virtualized and returns to virtualized user mode, it also clears the guest flag. A supervisor return executed in machine mode changes no flag.
- R8: The enable bits are writable only when the parameter DBLTRP_EN is non-zero. Otherwise they always read 0.
- R9: The host trap strobe sets the host flag when the machine enable is 1 and always clears the host interrupt enable. The guest trap strobe sets the guest flag when both enables are 1 and always clears the guest interrupt enable.
- R10: A return pulse or trap strobe in the same cycle as a register write drops that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| csr_sel | input | 2 | Register select: 0 host status, 1 guest status, 2 machine config, 3 hypervisor config |
| csr_wr | input | 1 | Write strobe for the selected register |
| csr_wdata | input | XLEN | Write data |
| csr_rdata | output | XLEN | Read data of the selected register, combinational |
| mret_p | input | 1 | Machine return pulse |
| sret_p | input | 1 | Supervisor return pulse |
| dret_p | input | 1 | Debug return pulse |
| ret_prv | input | 2 | Privilege being returned to |
| ret_virt | input | 1 | Virtualization mode being returned to |
| cur_prv | input | 2 | Privilege the supervisor return executes in |
| cur_virt | input | 1 | Virtualization mode the supervisor return executes in |
| trap_hs | input | 1 | Trap entry to host supervisor |
| trap_vs | input | 1 | Trap entry to guest supervisor |

## Verification
The assertions take four things for granted about the inputs:
- at most one of the three return pulses is high in a cycle;
- a return pulse never shares a cycle with a trap strobe;
- the two trap strobes never fire together;
- the privilege inputs never carry code 2.

The bench only ever raises one event per step, and it draws privilege values from the set user, supervisor, machine. The write-drop checks combine a single event with a write, which is the only overlap the design defines.

// File: rtl/sdt_pkg.sv
// Shared types for the supervisor double-trap guard.
// Assumes: privilege code 2 is never presented.
package sdt_pkg;
    typedef enum logic [1:0] {
        SEL_HSTAT = 2'd0,
        SEL_GSTAT = 2'd1,
        SEL_MCFG  = 2'd2,
        SEL_HCFG  = 2'd3
    } csr_sel_e;

    localparam logic [1:0] PRV_USER = 2'd0;
    localparam logic [1:0] PRV_SUPV = 2'd1;
    localparam logic [1:0] PRV_MACH = 2'd3;

    localparam int NUM_VIEWS = 2;
    localparam int VIEW_HOST = 0;
    localparam int VIEW_GUEST = 1;
endpackage

// File: rtl/sdt_envcfg_regs.sv
// Holds the machine and hypervisor double-trap enable bits.
// The hypervisor bit is gated by the machine bit on write and on read.
// Assumes: wr_m and wr_h are never high together.
module sdt_envcfg_regs #(
    parameter int DBLTRP_EN = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_m,
    input  logic wr_h,
    input  logic wdata_dte,
    output logic m_dte,
    output logic h_dte_eff
);
    logic m_q;
    logic h_q;

    generate
        if (DBLTRP_EN != 0) begin : g_ext
            // Update the enables; the hypervisor bit needs the machine bit set.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    m_q <= 1'b0;
                    h_q <= 1'b0;
                end else begin
                    if (wr_m) m_q <= wdata_dte;
                    if (wr_h && m_q) h_q <= wdata_dte;
                end
            end
        end else begin : g_noext
            // Without the extension both enables stay zero.
            always_ff @(posedge clk) begin
                m_q <= 1'b0;
                h_q <= 1'b0;
            end
        end
    endgenerate

    assign m_dte     = m_q;
    assign h_dte_eff = h_q & m_q;

    // R4: a hypervisor write while the machine bit is clear changes nothing
    a_r4_h_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_h && !m_q) |=> $stable(h_q));
    // R8: without the extension the machine enable never rises
    a_r8_no_ext: assert property (@(posedge clk) disable iff (!rst_n)
        (DBLTRP_EN == 0) |-> !m_q);
endmodule

// File: rtl/sdt_status_view.sv
// One supervisor status view: the double-trap flag and the interrupt enable.
// Priority: clear beats trap, and trap beats write.
// Assumes: wr is already gated off by the parent in event cycles.
module sdt_status_view (
    input  logic clk,
    input  logic rst_n,
    input  logic wr,
    input  logic w_sdt,
    input  logic w_sie,
    input  logic sdt_ok,
    input  logic trap,
    input  logic trap_ok,
    input  logic clr,
    output logic sdt_q,
    output logic sie_q
);
    logic nxt_sdt;

    // Flag value that a write would leave behind.
    always_comb begin
        nxt_sdt = sdt_ok ? w_sdt : sdt_q;
    end

    // State update for the flag and the interrupt enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sdt_q <= 1'b0;
            sie_q <= 1'b0;
        end else if (clr) begin
            sdt_q <= 1'b0;
        end else if (trap) begin
            if (trap_ok) sdt_q <= 1'b1;
            sie_q <= 1'b0;
        end else if (wr) begin
            sdt_q <= nxt_sdt;
            sie_q <= nxt_sdt ? 1'b0 : w_sie;
        end
    end

    // R5: a set flag never coexists with a set interrupt enable
    a_r5_sdt_excl_sie: assert property (@(posedge clk) disable iff (!rst_n)
        sdt_q |-> !sie_q);
    // R2 / R3: a write without permission keeps the flag
    a_r2_r3_hidden_wr: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !sdt_ok && !clr && !trap) |=> $stable(sdt_q));
    // R6 / R7: a clear request empties the flag
    a_r6_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !sdt_q);
    // R9: a trap always drops the interrupt enable
    a_r9_trap_sie: assert property (@(posedge clk) disable iff (!rst_n)
        (trap && !clr) |=> !sie_q);
endmodule

// File: rtl/sdt_ret_decode.sv
// Decides which flags a return event clears.
// Assumes: at most one return pulse is high, and privilege code 2 never appears.
module sdt_ret_decode
    import sdt_pkg::*;
(
    input  logic       mret_p,
    input  logic       sret_p,
    input  logic       dret_p,
    input  logic [1:0] ret_prv,
    input  logic       ret_virt,
    input  logic [1:0] cur_prv,
    input  logic       cur_virt,
    output logic       clr_host,
    output logic       clr_guest
);
    logic mach_like;
    logic to_vuser;
    logic sret_in_s;

    // Combine the return kinds into the two clear requests.
    always_comb begin
        mach_like = mret_p | dret_p;
        to_vuser  = ret_virt && (ret_prv == PRV_USER);
        sret_in_s = sret_p && (cur_prv == PRV_SUPV);
        clr_host  = (mach_like && ((ret_prv == PRV_USER) || ret_virt))
                  || (sret_in_s && !cur_virt);
        clr_guest = (mach_like && to_vuser)
                  || (sret_in_s && (cur_virt || to_vuser));
    end
endmodule

// File: rtl/sdt_guard_ctrl.sv
// Top level of the supervisor double-trap guard: the enable chain, two status
// views, return decoding and the read mux.
// Assumes: return pulses and trap strobes are mutually exclusive.
module sdt_guard_ctrl
    import sdt_pkg::*;
#(
    parameter int XLEN      = 64,
    parameter int SIE_POS   = 1,
    parameter int SDT_POS   = 24,
    parameter int DTE_POS   = 59,
    parameter int DBLTRP_EN = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      csr_sel,
    input  logic            csr_wr,
    input  logic [XLEN-1:0] csr_wdata,
    output logic [XLEN-1:0] csr_rdata,
    input  logic            mret_p,
    input  logic            sret_p,
    input  logic            dret_p,
    input  logic [1:0]      ret_prv,
    input  logic            ret_virt,
    input  logic [1:0]      cur_prv,
    input  logic            cur_virt,
    input  logic            trap_hs,
    input  logic            trap_vs
);
    csr_sel_e sel;
    logic     any_evt;
    logic     wr_ok;
    logic     m_dte;
    logic     h_dte;
    logic     clr_host;
    logic     clr_guest;
    logic     unused_wbits;
    logic [NUM_VIEWS-1:0] v_wr, v_ok, v_trap, v_trapok, v_clr, v_sdt, v_sie;

    assign sel          = csr_sel_e'(csr_sel);
    assign any_evt      = mret_p | sret_p | dret_p | trap_hs | trap_vs;
    assign wr_ok        = csr_wr & ~any_evt;
    assign unused_wbits = ^csr_wdata;

    sdt_envcfg_regs #(.DBLTRP_EN(DBLTRP_EN)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_m      (wr_ok && sel == SEL_MCFG),
        .wr_h      (wr_ok && sel == SEL_HCFG),
        .wdata_dte (csr_wdata[DTE_POS]),
        .m_dte     (m_dte),
        .h_dte_eff (h_dte)
    );

    sdt_ret_decode u_ret (
        .mret_p    (mret_p),
        .sret_p    (sret_p),
        .dret_p    (dret_p),
        .ret_prv   (ret_prv),
        .ret_virt  (ret_virt),
        .cur_prv   (cur_prv),
        .cur_virt  (cur_virt),
        .clr_host  (clr_host),
        .clr_guest (clr_guest)
    );

    // Per-view control wiring.
    always_comb begin
        v_wr[VIEW_HOST]      = wr_ok && sel == SEL_HSTAT;
        v_wr[VIEW_GUEST]     = wr_ok && sel == SEL_GSTAT;
        v_ok[VIEW_HOST]      = m_dte;
        v_ok[VIEW_GUEST]     = h_dte;
        v_trap[VIEW_HOST]    = trap_hs;
        v_trap[VIEW_GUEST]   = trap_vs;
        v_trapok[VIEW_HOST]  = m_dte;
        v_trapok[VIEW_GUEST] = h_dte;
        v_clr[VIEW_HOST]     = clr_host;
        v_clr[VIEW_GUEST]    = clr_guest;
    end

    generate
        for (genvar v = 0; v < NUM_VIEWS; v++) begin : g_view
            sdt_status_view u_view (
                .clk     (clk),
                .rst_n   (rst_n),
                .wr      (v_wr[v]),
                .w_sdt   (csr_wdata[SDT_POS]),
                .w_sie   (csr_wdata[SIE_POS]),
                .sdt_ok  (v_ok[v]),
                .trap    (v_trap[v]),
                .trap_ok (v_trapok[v]),
                .clr     (v_clr[v]),
                .sdt_q   (v_sdt[v]),
                .sie_q   (v_sie[v])
            );
        end
    endgenerate

    // Read mux with visibility masking.
    always_comb begin
        csr_rdata = '0;
        case (sel)
            SEL_HSTAT: begin
                csr_rdata[SDT_POS] = v_sdt[VIEW_HOST] & m_dte;
                csr_rdata[SIE_POS] = v_sie[VIEW_HOST];
            end
            SEL_GSTAT: begin
                csr_rdata[SDT_POS] = v_sdt[VIEW_GUEST] & h_dte;
                csr_rdata[SIE_POS] = v_sie[VIEW_GUEST];
            end
            SEL_MCFG: csr_rdata[DTE_POS] = m_dte;
            default:  csr_rdata[DTE_POS] = h_dte;
        endcase
    end

    // R2: the host flag is invisible without the machine enable
    a_r2_host_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_HSTAT && !m_dte) |-> !csr_rdata[SDT_POS]);
    // R3: the guest flag is invisible without the hypervisor enable
    a_r3_guest_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_GSTAT && !h_dte) |-> !csr_rdata[SDT_POS]);
    // R6: a machine return to user mode leaves the host flag clear
    a_r6_mret_user: assert property (@(posedge clk) disable iff (!rst_n)
        (mret_p && ret_prv == PRV_USER) |=> !v_sdt[VIEW_HOST]);
    // R10: a config write in an event cycle is dropped
    a_r10_wr_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_wr && any_evt && sel == SEL_MCFG) |=> $stable(m_dte));
endmodule

// File: tb/sdt_guard_ctrl_bench.sv
`timescale 1ns/1ps
module sdt_guard_ctrl_bench;
    localparam int SDTB = 24;
    localparam int SIEB = 1;
    localparam int DTEB = 59;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  csr_sel = 2'd0;
    logic        csr_wr = 1'b0;
    logic [63:0] csr_wdata = '0;
    logic [63:0] rdata, rdata_nx;
    logic        mret_p = 0, sret_p = 0, dret_p = 0, trap_hs = 0, trap_vs = 0;
    logic [1:0]  ret_prv = 2'd3, cur_prv = 2'd3;
    logic        ret_virt = 0, cur_virt = 0;

    int n_tests = 0;
    int n_fail = 0;
    bit done = 0;

    // Reference state.
    bit m_dte, h_dte, hs_sdt, hs_sie, vs_sdt, vs_sie;

    always #2.5 clk = ~clk;

    sdt_guard_ctrl u_sdt_guard_ctrl (
        .clk(clk), .rst_n(rst_n), .csr_sel(csr_sel), .csr_wr(csr_wr),
        .csr_wdata(csr_wdata), .csr_rdata(rdata), .mret_p(mret_p),
        .sret_p(sret_p), .dret_p(dret_p), .ret_prv(ret_prv),
        .ret_virt(ret_virt), .cur_prv(cur_prv), .cur_virt(cur_virt),
        .trap_hs(trap_hs), .trap_vs(trap_vs)
    );

    sdt_guard_ctrl #(.DBLTRP_EN(0)) u_noext (
        .clk(clk), .rst_n(rst_n), .csr_sel(csr_sel), .csr_wr(csr_wr),
        .csr_wdata(csr_wdata), .csr_rdata(rdata_nx), .mret_p(mret_p),
        .sret_p(sret_p), .dret_p(dret_p), .ret_prv(ret_prv),
        .ret_virt(ret_virt), .cur_prv(cur_prv), .cur_virt(cur_virt),
        .trap_hs(trap_hs), .trap_vs(trap_vs)
    );

    function automatic logic [63:0] exp_rd(input int s);
        logic [63:0] r = '0;
        case (s)
            0: begin r[SDTB] = hs_sdt & m_dte; r[SIEB] = hs_sie; end
            1: begin r[SDTB] = vs_sdt & h_dte & m_dte; r[SIEB] = vs_sie; end
            2: r[DTEB] = m_dte;
            default: r[DTEB] = h_dte & m_dte;
        endcase
        return r;
    endfunction

    // Compare all four registers against the reference.
    task automatic check_all(input string tag);
        for (int s = 0; s < 4; s++) begin
            csr_sel = s[1:0];
            #0.5;
            n_tests++;
            if (rdata !== exp_rd(s)) begin
                n_fail++;
                $display("FAIL %s sel=%0d actual=%h expected=%h", tag, s, rdata, exp_rd(s));
            end
        end
    endtask

    // One clocked step; the reference model applies the same event.
    task automatic step(input bit wr, input int sel, input logic [63:0] wd,
                        input int kind, input int rp, input bit rv,
                        input int cp, input bit cv);
        bit hok, gok, nsdt;
        csr_wr = wr; csr_sel = sel[1:0]; csr_wdata = wd;
        ret_prv = rp[1:0]; ret_virt = rv; cur_prv = cp[1:0]; cur_virt = cv;
        mret_p = (kind == 1); sret_p = (kind == 2); dret_p = (kind == 3);
        trap_hs = (kind == 4); trap_vs = (kind == 5);
        @(posedge clk);
        hok = m_dte;
        gok = m_dte & h_dte;
        if (kind == 1 || kind == 3) begin
            if (rp == 0 || rv) hs_sdt = 0;
            if (rv && rp == 0) vs_sdt = 0;
        end else if (kind == 2) begin
            if (cp == 1) begin
                if (cv) vs_sdt = 0;
                else begin
                    hs_sdt = 0;
                    if (rv && rp == 0) vs_sdt = 0;
                end
            end
        end else if (kind == 4) begin
            if (hok) hs_sdt = 1;
            hs_sie = 0;
        end else if (kind == 5) begin
            if (gok) vs_sdt = 1;
            vs_sie = 0;
        end else if (wr) begin
            case (sel)
                0: begin
                    nsdt = hok ? wd[SDTB] : hs_sdt;
                    hs_sdt = nsdt;
                    hs_sie = nsdt ? 1'b0 : wd[SIEB];
                end
                1: begin
                    nsdt = gok ? wd[SDTB] : vs_sdt;
                    vs_sdt = nsdt;
                    vs_sie = nsdt ? 1'b0 : wd[SIEB];
                end
                2: m_dte = wd[DTEB];
                default: if (m_dte) h_dte = wd[DTEB];
            endcase
        end
        @(negedge clk);
        csr_wr = 0; mret_p = 0; sret_p = 0; dret_p = 0; trap_hs = 0; trap_vs = 0;
    endtask

    function automatic logic [63:0] stat_w(input bit sdt, input bit sie);
        logic [63:0] w = '0;
        w[SDTB] = sdt;
        w[SIEB] = sie;
        return w;
    endfunction

    function automatic logic [63:0] cfg_w(input bit b);
        logic [63:0] w = '0;
        w[DTEB] = b;
        return w;
    endfunction

    task automatic wr_reg(input int sel, input logic [63:0] wd);
        step(1, sel, wd, 0, 3, 0, 3, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check_all("R1 reset");

        // R2 R3 R4 R5: enable chain by status write sweep
        for (int hp = 0; hp < 2; hp++)
            for (int m = 0; m < 2; m++)
                for (int h = 0; h < 2; h++) begin
                    wr_reg(3, cfg_w(hp[0]));
                    wr_reg(2, cfg_w(m[0]));
                    wr_reg(3, cfg_w(h[0]));
                    check_all("R4 cfg chain");
                    for (int v = 0; v < 2; v++)
                        for (int b = 0; b < 4; b++) begin
                            wr_reg(v, stat_w(b[1], b[0]));
                            check_all(v == 0 ? "R2 R5 host write" : "R3 R5 guest write");
                        end
                end

        // R2: a hidden host flag stays stored and reappears
        wr_reg(2, cfg_w(1));
        wr_reg(0, stat_w(1, 0));
        wr_reg(2, cfg_w(0));
        wr_reg(0, stat_w(0, 1));
        check_all("R2 hidden hold");
        wr_reg(2, cfg_w(1));
        check_all("R2 reappear");

        // R6 R7: return sweep
        for (int k = 1; k < 4; k++)
            for (int ri = 0; ri < 3; ri++)
                for (int rv = 0; rv < 2; rv++)
                    for (int ci = 0; ci < 2; ci++)
                        for (int cv = 0; cv < 2; cv++) begin
                            wr_reg(2, cfg_w(1));
                            wr_reg(3, cfg_w(1));
                            wr_reg(0, stat_w(1, 0));
                            wr_reg(1, stat_w(1, 0));
                            step(0, 0, '0, k, (ri == 2) ? 3 : ri, rv[0],
                                 (ci == 0) ? 1 : 3, cv[0]);
                            check_all(k == 2 ? "R7 sret clear" : "R6 mret dret clear");
                        end

        // R9: trap strobes across the enable combinations
        for (int m = 0; m < 2; m++)
            for (int h = 0; h < 2; h++) begin
                wr_reg(2, cfg_w(1));
                wr_reg(3, cfg_w(h[0]));
                wr_reg(2, cfg_w(m[0]));
                step(0, 0, '0, 1, 0, 1, 3, 0);
                wr_reg(0, stat_w(0, 1));
                wr_reg(1, stat_w(0, 1));
                step(0, 0, '0, 4, 3, 0, 3, 0);
                check_all("R9 host trap");
                step(0, 0, '0, 5, 3, 0, 3, 0);
                check_all("R9 guest trap");
            end

        // R10: writes dropped under events
        wr_reg(2, cfg_w(1));
        wr_reg(3, cfg_w(1));
        wr_reg(0, stat_w(1, 0));
        step(1, 0, stat_w(0, 1), 1, 3, 0, 3, 0);
        check_all("R10 write under mret");
        step(1, 2, cfg_w(0), 4, 3, 0, 3, 0);
        check_all("R10 write under trap");
        step(1, 1, stat_w(0, 1), 5, 3, 0, 3, 0);
        check_all("R10 write under guest trap");

        // R8: enables stuck at zero without the extension
        wr_reg(2, cfg_w(1));
        wr_reg(3, cfg_w(1));
        for (int s = 2; s < 4; s++) begin
            csr_sel = s[1:0];
            #0.5;
            n_tests++;
            if (rdata_nx !== 64'd0) begin
                n_fail++;
                $display("FAIL R8 sel=%0d actual=%h expected=%h", s, rdata_nx, 64'd0);
            end
        end
        wr_reg(0, stat_w(1, 1));
        csr_sel = 2'd0;
        #0.5;
        n_tests++;
        if (rdata_nx !== stat_w(0, 1)) begin
            n_fail++;
            $display("FAIL R8 host view actual=%h expected=%h", rdata_nx, stat_w(0, 1));
        end

        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule